// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Generator

This block turns bytes into asynchronous serial frames. Each frame has a start bit, a configurable data order, optional parity and one or two stop bits. A one-entry holding register sits in front of the shift register. Software can therefore queue the next byte while the current one is still going out, and consecutive frames leave the line with no idle gap between them.

On request the same shift path produces a long low break field followed by a one-bit high delimiter. This is the pattern used to open a frame on a single-wire automotive style bus. In that bus mode, byte stacking and parity are both disabled.

Bit timing comes from an external baud tick that pulses once per bit time. Two status flags, `buf_full` and `shift_busy`, let the host pace its writes. `tx_done` pulses at the end of every frame and every break. A write that would overwrite a pending byte is refused and reported on `wr_violation`.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, and on the clock after `pwr_en` is sampled low, `buf_full` and `shift_busy` are 0, any pending byte or frame is discarded, and `txd` sits at the idle level: 1 when `inv_out`=0.
- R2: A frame is a 0 start bit, then DATA_W data bits, then a 1 stop bit. `two_stop`=1 adds a second 1 stop bit. Each bit lasts from one baud tick to the next. The start bit begins at the first tick after the byte enters the shifter.
- R3: `msb_first`=0 sends data bit 0 first. `msb_first`=1 sends bit DATA_W-1 first.
- R4: With `par_en`=1 and `lin_mode`=0, one parity bit follows the data bits. `par_odd`=0 gives even parity, where the bit equals the XOR of the data bits. `par_odd`=1 gives the inverse of that XOR.
- R5: A write is accepted when `pwr_en` and `tx_en` are 1 and `buf_full` is 0. For a write to an idle block, the flag pair {`buf_full`,`shift_busy`} reads 10 on the next cycle and 01 on the cycle after. A write accepted during a frame gives 11. When that frame ends, the pair returns to 01 and the queued byte's start bit follows the stop bit directly.
- R6: A write while `buf_full`=1 is dropped. The pending byte is kept, and `wr_violation` pulses for one cycle on the next clock.
- R7: `tx_done` is a one-cycle pulse at the tick that ends the last stop bit of a frame, and at the tick that ends a break delimiter.
- R8: A `brk_req` pulse is accepted only when `pwr_en` and `tx_en` are 1 and both flags are 0. The line then goes low for BRK_LEN bit times (13 by default), followed by one high delimiter bit. A request made at any other time is ignored: the line does not change and no `tx_done` is produced.
- R9: `inv_out`=1 inverts `txd` for every bit, including the idle level. `txd` is registered and follows the internal line level one clock later.
- R10: With `lin_mode`=1, a write is accepted only when both flags are 0; otherwise it counts as a violation. No parity bit is sent, whatever `par_en` is set to.
- R11: While `tx_en`=0, writes are ignored: both flags stay as they were and `wr_violation` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Block enable; low forces idle |
| tx_en | input | 1 | Transmit enable for writes and break requests |
| lin_mode | input | 1 | Single-byte bus mode: no stacking, no parity |
| msb_first | input | 1 | Data bit order select |
| inv_out | input | 1 | Invert the serial output |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Send two stop bits |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to send |
| brk_req | input | 1 | Break field request pulse |
| txd | output | 1 | Serial line |
| buf_full | output | 1 | Holding register occupied |
| shift_busy | output | 1 | Shifter sending a frame or break |
| tx_done | output | 1 | End-of-frame / end-of-break pulse |
| wr_violation | output | 1 | Refused write pulse |

## Verification
The assertions take for granted that `msb_first` and `inv_out` hold still for as long as `tx_en` stays high. They also assume `lin_mode` changes only while both flags are 0, so that a stacked byte can never be present in bus mode. The stimulus changes every configuration input only after first dropping `tx_en` with the block idle, then raises `tx_en` again. Break requests and byte writes are never issued on the same clock, and `baud_tick` is a clean pulse of one cycle in every four.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_DELIM
    } stx_state_e;

    typedef struct packed {
        logic msb_first;
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic lin_mode;
    } stx_cfg_t;

endpackage

// File: rtl/stx_holdbuf.sv
module stx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lin_mode,
    input  logic              shift_busy,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              violation
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              viol;
    } hb_t;

    localparam hb_t HB_IDLE = '{full: 1'b0, data: '0, viol: 1'b0};

    hb_t  hb_q, hb_d;
    logic wr_req;
    logic wr_ok;

    assign wr_req = pwr_en && tx_en && wr_stb;
    assign wr_ok  = wr_req && !hb_q.full && (!lin_mode || !shift_busy);

    always_comb begin
        hb_d      = hb_q;
        hb_d.viol = wr_req && !wr_ok;
        if (!pwr_en) begin
            hb_d = HB_IDLE;
        end else begin
            if (take) begin
                hb_d.full = 1'b0;
            end
            if (wr_ok) begin
                hb_d.full = 1'b1;
                hb_d.data = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q <= HB_IDLE;
        end else begin
            hb_q <= hb_d;
        end
    end

    assign full      = hb_q.full;
    assign data      = hb_q.data;
    assign violation = hb_q.viol;

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && hb_q.full && pwr_en) |=> $stable(hb_q.data)) else $error("pending byte overwritten"); // R6

    AST_LIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && $past(lin_mode) && pwr_en) |-> !(hb_q.full && shift_busy)) else $error("byte stacked in bus mode"); // R10

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LEN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              brk_req,
    input  stx_cfg_t          cfg,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take,
    output logic              line,
    output logic              busy,
    output logic              done
);

    localparam int CNT_MAX = (BRK_LEN > DATA_W) ? BRK_LEN : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        stx_state_e        st;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              par;
        logic              brk;
        logic              line;
        logic              done;
    } shf_t;

    localparam shf_t SHF_IDLE = '{st: ST_IDLE, sh: '0, cnt: '0, par: 1'b0,
                                  brk: 1'b0, line: 1'b1, done: 1'b0};

    shf_t              sf_q, sf_d;
    logic              par_on;
    logic              next_bit;
    logic [DATA_W-1:0] sh_adv;
    logic              frame_end;
    logic              chain;
    logic              start_ok;
    logic              brk_go;

    assign par_on    = cfg.par_en && !cfg.lin_mode;
    assign next_bit  = cfg.msb_first ? sf_q.sh[DATA_W-1] : sf_q.sh[0];
    assign sh_adv    = cfg.msb_first ? (sf_q.sh << 1) : (sf_q.sh >> 1);
    assign frame_end = baud_tick &&
                       ((sf_q.st == ST_STOP && !(cfg.two_stop && sf_q.cnt == '0)) ||
                        sf_q.st == ST_DELIM);
    assign chain     = frame_end && buf_full && !cfg.lin_mode;
    assign start_ok  = (sf_q.st == ST_IDLE) && buf_full;
    assign brk_go    = (sf_q.st == ST_IDLE) && !buf_full && pwr_en && tx_en && brk_req;
    assign take      = pwr_en && (start_ok || chain);

    always_comb begin
        sf_d      = sf_q;
        sf_d.done = 1'b0;
        if (!pwr_en) begin
            sf_d = SHF_IDLE;
        end else begin
            case (sf_q.st)
                ST_IDLE: begin
                    if (start_ok) begin
                        sf_d.st  = ST_ARM;
                        sf_d.sh  = buf_data;
                        sf_d.par = (^buf_data) ^ cfg.par_odd;
                        sf_d.brk = 1'b0;
                    end else if (brk_go) begin
                        sf_d.st  = ST_ARM;
                        sf_d.brk = 1'b1;
                    end
                end
                ST_ARM: begin
                    if (baud_tick) begin
                        sf_d.line = 1'b0;
                        if (sf_q.brk) begin
                            sf_d.st  = ST_BRK;
                            sf_d.cnt = CNT_W'(1);
                        end else begin
                            sf_d.st = ST_START;
                        end
                    end
                end
                ST_START: begin
                    if (baud_tick) begin
                        sf_d.st   = ST_DATA;
                        sf_d.line = next_bit;
                        sf_d.sh   = sh_adv;
                        sf_d.cnt  = CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (baud_tick) begin
                        if (sf_q.cnt == CNT_W'(DATA_W)) begin
                            if (par_on) begin
                                sf_d.st   = ST_PAR;
                                sf_d.line = sf_q.par;
                            end else begin
                                sf_d.st   = ST_STOP;
                                sf_d.line = 1'b1;
                                sf_d.cnt  = '0;
                            end
                        end else begin
                            sf_d.line = next_bit;
                            sf_d.sh   = sh_adv;
                            sf_d.cnt  = sf_q.cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (baud_tick) begin
                        sf_d.st   = ST_STOP;
                        sf_d.line = 1'b1;
                        sf_d.cnt  = '0;
                    end
                end
                ST_STOP: begin
                    if (baud_tick && cfg.two_stop && sf_q.cnt == '0) begin
                        sf_d.cnt = CNT_W'(1);
                    end
                end
                ST_BRK: begin
                    if (baud_tick) begin
                        if (sf_q.cnt == CNT_W'(BRK_LEN)) begin
                            sf_d.st   = ST_DELIM;
                            sf_d.line = 1'b1;
                        end else begin
                            sf_d.cnt = sf_q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (frame_end) begin
                sf_d.done = 1'b1;
                sf_d.brk  = 1'b0;
                if (chain) begin
                    sf_d.st   = ST_START;
                    sf_d.line = 1'b0;
                    sf_d.sh   = buf_data;
                    sf_d.par  = (^buf_data) ^ cfg.par_odd;
                end else begin
                    sf_d.st   = ST_IDLE;
                    sf_d.line = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sf_q <= SHF_IDLE;
        end else begin
            sf_q <= sf_d;
        end
    end

    assign line = sf_q.line;
    assign busy = (sf_q.st != ST_IDLE);
    assign done = sf_q.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("completion pulse too long"); // R7

    AST_BRK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && sf_q.st != ST_IDLE && !sf_q.brk) |=> !sf_q.brk) else $error("break accepted while busy"); // R8

    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_q.st == ST_BRK && $past(sf_q.st) == ST_BRK) |-> !line) else $error("line high inside break"); // R8

endmodule

// File: rtl/stx_lineout.sv
module stx_lineout (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic inv,
    output logic txd
);

    logic txd_d, txd_q;

    always_comb begin
        txd_d = line ^ inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd_q <= 1'b1;
        end else begin
            txd_q <= txd_d;
        end
    end

    assign txd = txd_q;

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import stx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LEN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic              lin_mode,
    input  logic              msb_first,
    input  logic              inv_out,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_req,
    output logic              txd,
    output logic              buf_full,
    output logic              shift_busy,
    output logic              tx_done,
    output logic              wr_violation
);

    stx_cfg_t          cfg;
    logic              take;
    logic [DATA_W-1:0] held;
    logic              line;

    assign cfg = '{msb_first: msb_first, par_en: par_en, par_odd: par_odd,
                   two_stop: two_stop, lin_mode: lin_mode};

    stx_holdbuf #(.DATA_W(DATA_W)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_en     (pwr_en),
        .tx_en      (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .lin_mode   (lin_mode),
        .shift_busy (shift_busy),
        .take       (take),
        .full       (buf_full),
        .data       (held),
        .violation  (wr_violation)
    );

    stx_shifter #(.DATA_W(DATA_W), .BRK_LEN(BRK_LEN)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .brk_req   (brk_req),
        .cfg       (cfg),
        .buf_full  (buf_full),
        .buf_data  (held),
        .take      (take),
        .line      (line),
        .busy      (shift_busy),
        .done      (tx_done)
    );

    stx_lineout out_i (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (line),
        .inv   (inv_out),
        .txd   (txd)
    );

    AST_PWR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (!buf_full && !shift_busy)) else $error("power-off did not idle"); // R1

    AST_FLAG_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && shift_busy && pwr_en) |=> shift_busy) else $error("flags left 11 without shifting"); // R5

    AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && tx_en && wr_stb && !buf_full && (!lin_mode || !shift_busy)) |=> buf_full) else $error("legal write lost"); // R5

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_busy && $past(!shift_busy) && $stable(inv_out)) |-> (txd == !inv_out)) else $error("idle level wrong"); // R9

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> ($stable(inv_out) && $stable(msb_first))) else $error("config changed while enabled"); // R9

endmodule

// File: tb/uart_tx_brk_tb_top.sv
`timescale 1ns/1ps
module uart_tx_brk_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0, tx_en = 1'b0, lin_mode = 1'b0;
    logic       msb_first = 1'b0, inv_out = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       baud_tick = 1'b0, wr_stb = 1'b0, brk_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, buf_full, shift_busy, tx_done, wr_violation;

    int  checks = 0;
    int  fails = 0;
    int  done_cnt = 0;
    int  viol_cnt = 0;
    bit  finished = 1'b0;
    bit  cap_en = 1'b0;
    logic cap[$];
    logic expq[$];

    always #10 clk = ~clk;

    uart_tx_brk dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .lin_mode(lin_mode),
        .msb_first(msb_first), .inv_out(inv_out), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .baud_tick(baud_tick), .wr_stb(wr_stb), .wr_data(wr_data),
        .brk_req(brk_req), .txd(txd), .buf_full(buf_full), .shift_busy(shift_busy),
        .tx_done(tx_done), .wr_violation(wr_violation)
    );

    // baud tick every 4 cycles; each bit captured two cycles after its tick
    initial begin
        forever begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
            @(negedge clk);
            if (cap_en) cap.push_back(txd ^ inv_out);
            @(negedge clk);
        end
    end

    always @(negedge clk) begin
        if (tx_done) done_cnt++;
        if (wr_violation) viol_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic pulse_brk();
        brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((buf_full || shift_busy) && n < 3000) begin
            @(negedge clk); n++;
        end
        if (n >= 3000) chk(1'b0, req, "timeout waiting idle", n, 0);
    endtask

    task automatic configure(input logic m, input logic iv, input logic pe, input logic po,
                             input logic ts, input logic ln);
        tx_en = 1'b0; @(negedge clk);
        msb_first = m; inv_out = iv; par_en = pe; par_odd = po; two_stop = ts; lin_mode = ln;
        @(negedge clk); tx_en = 1'b1; @(negedge clk);
    endtask

    task automatic add_frame(input logic [7:0] d);
        expq.push_back(1'b0);
        for (int i = 0; i < 8; i++) expq.push_back(msb_first ? d[7-i] : d[i]);
        if (par_en && !lin_mode) expq.push_back((^d) ^ par_odd);
        expq.push_back(1'b1);
        if (two_stop) expq.push_back(1'b1);
    endtask

    task automatic add_ones(input int n);
        for (int i = 0; i < n; i++) expq.push_back(1'b1);
    endtask

    task automatic begin_cap();
        cap.delete(); expq.delete(); cap_en = 1'b1;
    endtask

    task automatic check_stream(input string req, input string what);
        int s = 0;
        int bad = -1;
        int a = -1;
        cap_en = 1'b0;
        if (expq.size() > 0 && expq[0] == 1'b0)
            while (s < cap.size() && cap[s] == 1'b1) s++;
        for (int i = 0; i < expq.size(); i++) begin
            if (s + i >= cap.size() || cap[s+i] !== expq[i]) begin
                bad = i;
                if (s + i < cap.size()) a = int'(cap[s+i]);
                break;
            end
        end
        chk(bad < 0, req, $sformatf("%s stream bit %0d", what, bad), a, (bad >= 0) ? int'(expq[bad]) : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d0;
        int v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(!buf_full && !shift_busy, "R1", "flags after reset", {buf_full, shift_busy}, 0);
        pwr_en = 1'b1; @(negedge clk);

        // R2 R3 R4 R9 R7: sweep over all framing options and inversion
        d0 = done_cnt;
        for (int c = 0; c < 32; c++) begin
            configure(c[0], c[4], c[1], c[2], c[3], 1'b0);
            for (int k = 0; k < 4; k++) begin
                logic [7:0] d;
                d = 8'(c * 29 + k * 83 + 1);
                begin_cap();
                add_frame(d);
                send(d);
                wait_idle("R2");
                ticks(2);
                check_stream("R2", $sformatf("cfg %0d data %0h (R3 R4 R9)", c, d));
            end
        end
        chk(done_cnt - d0 == 128, "R7", "done pulses over sweep", done_cnt - d0, 128);

        // R5 back-to-back flag sequence and gapless frames
        configure(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        begin_cap();
        add_frame(8'h3C); add_frame(8'hC1);
        d0 = done_cnt;
        send(8'h3C);
        chk({buf_full, shift_busy} == 2'b10, "R5", "flags after first write", {buf_full, shift_busy}, 2);
        @(negedge clk);
        chk({buf_full, shift_busy} == 2'b01, "R5", "flags after handoff", {buf_full, shift_busy}, 1);
        send(8'hC1);
        chk({buf_full, shift_busy} == 2'b11, "R5", "flags after stacked write", {buf_full, shift_busy}, 3);
        while (!tx_done) @(negedge clk);
        chk({buf_full, shift_busy} == 2'b01, "R5", "flags at frame end", {buf_full, shift_busy}, 1);
        wait_idle("R5");
        ticks(2);
        check_stream("R5", "two stacked frames");
        chk(done_cnt - d0 == 2, "R7", "done pulses for two frames", done_cnt - d0, 2);

        // R6 write while buffer full is refused
        begin_cap();
        add_frame(8'h81); add_frame(8'h7E);
        v0 = viol_cnt;
        send(8'h81);
        send(8'hFF);
        chk(wr_violation == 1'b1, "R6", "violation pulse", wr_violation, 1);
        send(8'h7E);
        wait_idle("R6");
        ticks(2);
        check_stream("R6", "dropped byte absent");
        chk(viol_cnt - v0 == 1, "R6", "violation count", viol_cnt - v0, 1);

        // R8 break field
        begin_cap();
        for (int i = 0; i < 13; i++) expq.push_back(1'b0);
        add_ones(1);
        d0 = done_cnt;
        pulse_brk();
        chk(shift_busy == 1'b1, "R8", "busy after break request", shift_busy, 1);
        wait_idle("R8");
        ticks(3);
        check_stream("R8", "break 13 low then delimiter");
        chk(done_cnt - d0 == 1, "R7", "done pulse after break", done_cnt - d0, 1);

        // R8 break during a frame ignored
        begin_cap();
        add_frame(8'h55); add_ones(16);
        d0 = done_cnt;
        send(8'h55);
        ticks(3);
        pulse_brk();
        wait_idle("R8");
        ticks(18);
        check_stream("R8", "break during frame ignored");
        chk(done_cnt - d0 == 1, "R8", "single done with ignored break", done_cnt - d0, 1);

        // R8 R11 break and write with tx_en low ignored
        tx_en = 1'b0; @(negedge clk);
        begin_cap();
        add_ones(20);
        d0 = done_cnt; v0 = viol_cnt;
        pulse_brk();
        send(8'h12);
        chk(!buf_full && !shift_busy, "R11", "flags after disabled write", {buf_full, shift_busy}, 0);
        ticks(22);
        check_stream("R8", "disabled break ignored");
        chk(done_cnt == d0 && viol_cnt == v0, "R11", "no done/violation when disabled", done_cnt - d0 + viol_cnt - v0, 0);
        tx_en = 1'b1; @(negedge clk);

        // R10 bus mode: no stacking, no parity
        configure(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        begin_cap();
        add_frame(8'hA7); add_ones(16);
        v0 = viol_cnt;
        send(8'hA7);
        @(negedge clk);
        chk({buf_full, shift_busy} == 2'b01, "R10", "flags after handoff", {buf_full, shift_busy}, 1);
        send(8'h11);
        chk(wr_violation == 1'b1 && buf_full == 1'b0, "R10", "write while busy refused", {wr_violation, buf_full}, 2);
        wait_idle("R10");
        ticks(18);
        check_stream("R10", "single frame without parity");
        chk(viol_cnt - v0 == 1, "R10", "violation count", viol_cnt - v0, 1);

        // R1 power-off mid-frame
        configure(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h00);
        ticks(4);
        pwr_en = 1'b0;
        @(negedge clk);
        chk(!buf_full && !shift_busy, "R1", "flags after power-off", {buf_full, shift_busy}, 0);
        @(negedge clk);
        chk(txd == 1'b0, "R1", "inverted idle level after power-off (R9)", txd, 0);
        pwr_en = 1'b1; @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule